// File: doc/BRIEF.md
# Pipelined Ray-Box Slab Tester

This block decides, once per clock, whether a ray passes through an axis-aligned bounding box. Each operand set carries the two opposite corners of the box, the ray origin, the reciprocal of the ray direction on every axis and a closest-hit limit. The block treats the box as three slabs, one per axis, each bounded by two parallel planes. For each slab it forms the distances at which the ray crosses the two planes and sorts them into a near and a far value. It then takes the latest entry and the earliest exit across the three slabs and tests whether that span is non-empty, lies ahead of the origin and starts before the limit.

All arithmetic is signed fixed point. Coordinates, reciprocals and the limit share one format, so no floating-point units are needed. The pipeline has eight register stages: two for the subtracts, two for the multiplies and four for the comparisons. It accepts a new operand set on every cycle, has no stall input, and carries a caller-chosen tag with each set so that results can be matched to their requests.

Top module: `slab_tester`

## Requirements
- R1: While `rst_n` is low, and for the first eight cycles after it is released, `out_valid` and `out_hit` are 0.
- R2: An operand set presented with `in_valid` high in cycle c produces exactly one result, with `out_valid` high, in cycle c+8. Sets presented in consecutive cycles produce results in consecutive cycles.
- R3: `out_tag` carries the `in_tag` of the operand set whose result is being shown.
- R4: Every scalar is a DW-bit two's-complement number with FRAC fraction bits. The packed vectors hold x in bits [DW-1:0], y in [2*DW-1:DW] and z in [3*DW-1:2*DW]. The plane distance for each corner and axis is ((corner - origin) * reciprocal) arithmetically shifted right by FRAC, and it is computed without overflow.
- R5: On each axis the near distance is the smaller of the two plane distances and the far distance is the larger, so swapping the two corners or negating a reciprocal's sign gives the matching correct result.
- R6: The entry distance is the largest of the three near distances and the exit distance is the smallest of the three far distances. `out_entry` shows the entry distance, sign-extended to 2*DW-FRAC+1 bits with FRAC fraction bits, for every valid result, whether it is a hit or a miss.
- R7: `out_hit` is 1 only if entry <= exit, exit >= 0 and entry < `t_limit`. Boxes behind the origin miss, a ray starting inside the box hits with a negative entry, a box that only touches the ray (entry = exit) hits, and entry = limit misses.
- R8: In cycles where `in_valid` is low, the other inputs have no effect: no result appears eight cycles later, and `out_hit` stays 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| in_valid | input | 1 | Operand set present this cycle |
| in_tag | input | TAGW | Caller tag carried with the operand set |
| corner_a | input | 3*DW | First box corner {z, y, x} |
| corner_b | input | 3*DW | Opposite box corner {z, y, x} |
| ray_org | input | 3*DW | Ray origin {z, y, x} |
| ray_rinv | input | 3*DW | Per-axis reciprocal of the ray direction {z, y, x} |
| t_limit | input | DW | Closest hit found so far; entry must be below it |
| out_valid | output | 1 | Result present this cycle |
| out_tag | output | TAGW | Tag of the result |
| out_hit | output | 1 | Ray crosses the box within the limit |
| out_entry | output | 2*DW-FRAC+1 | Entry distance into the box |

## Verification
The bench builds the block with DW=12, FRAC=4 and TAGW=5. The narrow words let stimulus reach the full corner and origin range, including -2048, so the widest differences and products that can occur are exercised. A 5-bit tag wraps many times during the streamed phase, which tests tag alignment across wrap-around. With a 16-step unit, directed cases can place entry and exit exactly on the limit and on each other, which tests the strict and non-strict comparison boundaries.

// File: rtl/slab_pkg.sv
package slab_pkg;
  // Register stages from operand capture to result register.
  localparam int unsigned SLAB_STAGES = 8;
  // Sideband (valid/tag/limit) stages needed before the final decision stage.
  localparam int unsigned SIDE_STAGES = SLAB_STAGES - 1;

  // Width of a plane distance: (DW+1)x(DW) product, FRAC bits dropped.
  function automatic int t_width(input int dw, input int frac);
    return 2 * dw + 1 - frac;
  endfunction
endpackage

// File: rtl/slab_sideband.sv
// Delay line for per-operand control that rides alongside the datapath.
module slab_sideband #(
  parameter int DW    = 16,
  parameter int TAGW  = 8,
  parameter int DEPTH = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [TAGW-1:0]      in_tag,
  input  logic [DW-1:0]        in_limit,
  output logic [DEPTH:0]       stage_vld,
  output logic [TAGW-1:0]      tag_last,
  output logic [DW-1:0]        limit_last
);
  logic [DEPTH-1:0]            vld_q, vld_d;
  logic [DEPTH-1:0][TAGW-1:0]  tag_q, tag_d, tag_src;
  logic [DEPTH-1:0][DW-1:0]    lim_q, lim_d, lim_src;
  logic [DEPTH-1:0]            ld_en;

  assign stage_vld = {vld_q, in_valid};

  always_comb begin
    vld_d   = {vld_q[DEPTH-2:0], in_valid};
    tag_src = {tag_q[DEPTH-2:0], in_tag};
    lim_src = {lim_q[DEPTH-2:0], in_limit};
    ld_en   = stage_vld[DEPTH-1:0];
    for (int j = 0; j < DEPTH; j++) begin
      tag_d[j] = ld_en[j] ? tag_src[j] : tag_q[j];
      lim_d[j] = ld_en[j] ? lim_src[j] : lim_q[j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      tag_q <= '0;
      lim_q <= '0;
    end else begin
      vld_q <= vld_d;
      tag_q <= tag_d;
      lim_q <= lim_d;
    end
  end

  assign tag_last   = tag_q[DEPTH-1];
  assign limit_last = lim_q[DEPTH-1];
endmodule

// File: rtl/slab_axis.sv
// One slab: two subtract stages, two multiply stages, one sort stage.
module slab_axis #(
  parameter int DW   = 16,
  parameter int FRAC = 8,
  localparam int TW  = slab_pkg::t_width(DW, FRAC)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [4:0]            stg_en,   // valid entering stages 1..5
  input  logic signed [DW-1:0]  plane_a,
  input  logic signed [DW-1:0]  plane_b,
  input  logic signed [DW-1:0]  org,
  input  logic signed [DW-1:0]  rinv,
  output logic signed [TW-1:0]  t_near,
  output logic signed [TW-1:0]  t_far
);
  localparam int DW1 = DW + 1;
  localparam int PW  = 2 * DW + 1;

  // stage 1/2: differences, reciprocal delayed alongside
  logic signed [DW1-1:0] dif1a_q, dif1a_d, dif1b_q, dif1b_d;
  logic signed [DW-1:0]  rcp1_q, rcp1_d;
  logic signed [DW1-1:0] dif2a_q, dif2a_d, dif2b_q, dif2b_d;
  logic signed [DW-1:0]  rcp2_q, rcp2_d;
  // stage 3/4: products, then rescaled distances
  logic signed [PW-1:0]  prd3a_q, prd3a_d, prd3b_q, prd3b_d;
  logic signed [TW-1:0]  dst4a_q, dst4a_d, dst4b_q, dst4b_d;
  // stage 5: sorted
  logic signed [TW-1:0]  near5_q, near5_d, far5_q, far5_d;
  logic signed [PW-1:0]  mul_ra, mul_rb, mul_rr;
  logic                  a_first;

  always_comb begin
    dif1a_d = stg_en[0] ? (DW1'(plane_a) - DW1'(org)) : dif1a_q;
    dif1b_d = stg_en[0] ? (DW1'(plane_b) - DW1'(org)) : dif1b_q;
    rcp1_d  = stg_en[0] ? rinv : rcp1_q;

    dif2a_d = stg_en[1] ? dif1a_q : dif2a_q;
    dif2b_d = stg_en[1] ? dif1b_q : dif2b_q;
    rcp2_d  = stg_en[1] ? rcp1_q  : rcp2_q;

    mul_ra  = PW'(dif2a_q);
    mul_rb  = PW'(dif2b_q);
    mul_rr  = PW'(rcp2_q);
    prd3a_d = stg_en[2] ? (mul_ra * mul_rr) : prd3a_q;
    prd3b_d = stg_en[2] ? (mul_rb * mul_rr) : prd3b_q;

    dst4a_d = stg_en[3] ? TW'(prd3a_q >>> FRAC) : dst4a_q;
    dst4b_d = stg_en[3] ? TW'(prd3b_q >>> FRAC) : dst4b_q;

    a_first = (dst4a_q < dst4b_q);
    near5_d = stg_en[4] ? (a_first ? dst4a_q : dst4b_q) : near5_q;
    far5_d  = stg_en[4] ? (a_first ? dst4b_q : dst4a_q) : far5_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dif1a_q <= '0; dif1b_q <= '0; rcp1_q <= '0;
      dif2a_q <= '0; dif2b_q <= '0; rcp2_q <= '0;
      prd3a_q <= '0; prd3b_q <= '0;
      dst4a_q <= '0; dst4b_q <= '0;
      near5_q <= '0; far5_q  <= '0;
    end else begin
      dif1a_q <= dif1a_d; dif1b_q <= dif1b_d; rcp1_q <= rcp1_d;
      dif2a_q <= dif2a_d; dif2b_q <= dif2b_d; rcp2_q <= rcp2_d;
      prd3a_q <= prd3a_d; prd3b_q <= prd3b_d;
      dst4a_q <= dst4a_d; dst4b_q <= dst4b_d;
      near5_q <= near5_d; far5_q  <= far5_d;
    end
  end

  assign t_near = near5_q;
  assign t_far  = far5_q;
endmodule

// File: rtl/slab_reduce.sv
// Stages 6..8: merge x/y, fold in z, then the hit decision.
module slab_reduce #(
  parameter int DW   = 16,
  parameter int FRAC = 8,
  parameter int TAGW = 8,
  localparam int TW  = slab_pkg::t_width(DW, FRAC)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  vld5,
  input  logic                  vld6,
  input  logic                  vld7,
  input  logic [TAGW-1:0]       tag7,
  input  logic signed [DW-1:0]  limit7,
  input  logic [2:0][TW-1:0]    near_in,
  input  logic [2:0][TW-1:0]    far_in,
  output logic                  res_valid,
  output logic [TAGW-1:0]       res_tag,
  output logic                  res_hit,
  output logic [TW-1:0]         res_entry
);
  logic signed [TW-1:0] nx, ny, nz, fx, fy, fz;
  logic signed [TW-1:0] ent6_q, ent6_d, ext6_q, ext6_d, nz6_q, nz6_d, fz6_q, fz6_d;
  logic signed [TW-1:0] ent7_q, ent7_d, ext7_q, ext7_d;
  logic signed [TW-1:0] ent8_q, ent8_d, lim_ext;
  logic                 vld8_q, hit8_q, hit8_d;
  logic [TAGW-1:0]      tag8_q, tag8_d;
  logic                 span_ok, ahead_ok, limit_ok;

  always_comb begin
    nx = $signed(near_in[0]); ny = $signed(near_in[1]); nz = $signed(near_in[2]);
    fx = $signed(far_in[0]);  fy = $signed(far_in[1]);  fz = $signed(far_in[2]);

    ent6_d = vld5 ? ((nx > ny) ? nx : ny) : ent6_q;
    ext6_d = vld5 ? ((fx < fy) ? fx : fy) : ext6_q;
    nz6_d  = vld5 ? nz : nz6_q;
    fz6_d  = vld5 ? fz : fz6_q;

    ent7_d = vld6 ? ((ent6_q > nz6_q) ? ent6_q : nz6_q) : ent7_q;
    ext7_d = vld6 ? ((ext6_q < fz6_q) ? ext6_q : fz6_q) : ext7_q;

    lim_ext  = TW'(limit7);
    span_ok  = (ent7_q <= ext7_q);
    ahead_ok = (ext7_q >= 0);
    limit_ok = (ent7_q < lim_ext);
    hit8_d   = vld7 & span_ok & ahead_ok & limit_ok;
    ent8_d   = vld7 ? ent7_q : ent8_q;
    tag8_d   = vld7 ? tag7   : tag8_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent6_q <= '0; ext6_q <= '0; nz6_q <= '0; fz6_q <= '0;
      ent7_q <= '0; ext7_q <= '0;
      ent8_q <= '0; vld8_q <= 1'b0; hit8_q <= 1'b0; tag8_q <= '0;
    end else begin
      ent6_q <= ent6_d; ext6_q <= ext6_d; nz6_q <= nz6_d; fz6_q <= fz6_d;
      ent7_q <= ent7_d; ext7_q <= ext7_d;
      ent8_q <= ent8_d; vld8_q <= vld7; hit8_q <= hit8_d; tag8_q <= tag8_d;
    end
  end

  assign res_valid = vld8_q;
  assign res_tag   = tag8_q;
  assign res_hit   = hit8_q;
  assign res_entry = ent8_q;
endmodule

// File: rtl/slab_tester.sv
// Ray versus axis-aligned box, one test per cycle, eight-stage pipeline.
module slab_tester #(
  parameter int DW   = 16,
  parameter int FRAC = 8,
  parameter int TAGW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [TAGW-1:0]       in_tag,
  input  logic [3*DW-1:0]       corner_a,
  input  logic [3*DW-1:0]       corner_b,
  input  logic [3*DW-1:0]       ray_org,
  input  logic [3*DW-1:0]       ray_rinv,
  input  logic [DW-1:0]         t_limit,
  output logic                  out_valid,
  output logic [TAGW-1:0]       out_tag,
  output logic                  out_hit,
  output logic [2*DW-FRAC:0]    out_entry
);
  localparam int TW   = slab_pkg::t_width(DW, FRAC);
  localparam int SIDE = slab_pkg::SIDE_STAGES;

  logic [SIDE:0]          vld;
  logic [TAGW-1:0]        tag_at7;
  logic [DW-1:0]          lim_at7;
  logic [2:0][TW-1:0]     near_ax, far_ax;

  slab_sideband #(.DW(DW), .TAGW(TAGW), .DEPTH(SIDE)) side_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_tag     (in_tag),
    .in_limit   (t_limit),
    .stage_vld  (vld),
    .tag_last   (tag_at7),
    .limit_last (lim_at7)
  );

  for (genvar g = 0; g < 3; g++) begin : g_axis
    logic signed [TW-1:0] n_g, f_g;
    slab_axis #(.DW(DW), .FRAC(FRAC)) axis_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .stg_en  (vld[4:0]),
      .plane_a (corner_a[g*DW +: DW]),
      .plane_b (corner_b[g*DW +: DW]),
      .org     (ray_org[g*DW +: DW]),
      .rinv    (ray_rinv[g*DW +: DW]),
      .t_near  (n_g),
      .t_far   (f_g)
    );
    assign near_ax[g] = n_g;
    assign far_ax[g]  = f_g;
  end

  slab_reduce #(.DW(DW), .FRAC(FRAC), .TAGW(TAGW)) red_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .vld5      (vld[5]),
    .vld6      (vld[6]),
    .vld7      (vld[7]),
    .tag7      (tag_at7),
    .limit7    (lim_at7),
    .near_in   (near_ax),
    .far_in    (far_ax),
    .res_valid (out_valid),
    .res_tag   (out_tag),
    .res_hit   (out_hit),
    .res_entry (out_entry)
  );
endmodule

// File: rtl/slab_tester_chk.sv
module slab_tester_chk #(
  parameter int DW   = 16,
  parameter int FRAC = 8,
  parameter int TAGW = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [TAGW-1:0]     in_tag,
  input logic [DW-1:0]       t_limit,
  input logic                out_valid,
  input logic [TAGW-1:0]     out_tag,
  input logic                out_hit,
  input logic [2*DW-FRAC:0]  out_entry
);
  localparam int TW = 2 * DW + 1 - FRAC;

  logic [3:0]           since_rst;
  logic signed [TW-1:0] lim_wide;

  assign lim_wide = TW'($signed(t_limit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rst <= '0;
    else if (since_rst != 4'hF) since_rst <= since_rst + 4'd1;
  end

  // R1: nothing can emerge before the first operand set has crossed all stages
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < 4'd8) |-> !out_valid);

  // R2: a result exactly eight cycles after each accepted set, none otherwise
  a_r2_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 4'd8) |-> (out_valid == $past(in_valid, 8)));

  // R3: tag follows its operand set
  a_r3_tag_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ((since_rst >= 4'd8) && out_valid) |-> (out_tag == $past(in_tag, 8)));

  // R8: a hit is only reported together with a result
  a_r8_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_hit |-> out_valid);

  // R7: a hit always starts before the limit supplied with its set
  a_r7_hit_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
    ((since_rst >= 4'd8) && out_hit) |->
      ($signed(out_entry) < $past(lim_wide, 8)));
endmodule

bind slab_tester slab_tester_chk #(.DW(DW), .FRAC(FRAC), .TAGW(TAGW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_tag    (in_tag),
  .t_limit   (t_limit),
  .out_valid (out_valid),
  .out_tag   (out_tag),
  .out_hit   (out_hit),
  .out_entry (out_entry)
);

// File: tb/slab_tester_tb_top.sv
`timescale 1ns/1ps
module slab_tester_tb_top;
  localparam int DW   = 12;
  localparam int FRAC = 4;
  localparam int TAGW = 5;
  localparam int TW   = 2 * DW + 1 - FRAC;
  localparam int ONE  = 1 << FRAC;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 in_valid;
  logic [TAGW-1:0]      in_tag;
  logic [3*DW-1:0]      corner_a, corner_b, ray_org, ray_rinv;
  logic [DW-1:0]        t_limit;
  logic                 out_valid;
  logic [TAGW-1:0]      out_tag;
  logic                 out_hit;
  logic [TW-1:0]        out_entry;

  always #10 clk = ~clk;  // 50 MHz

  slab_tester #(.DW(DW), .FRAC(FRAC), .TAGW(TAGW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
    .corner_a(corner_a), .corner_b(corner_b), .ray_org(ray_org),
    .ray_rinv(ray_rinv), .t_limit(t_limit), .out_valid(out_valid),
    .out_tag(out_tag), .out_hit(out_hit), .out_entry(out_entry)
  );

  typedef struct {
    logic [TAGW-1:0] tag;
    bit              hit;
    longint          entry;
    int              due;
    string           req;
  } exp_t;

  exp_t   sb_q[$];
  int     n_checks = 0;
  int     n_errors = 0;
  int     edge_cnt = 0;
  bit     mon_on   = 1'b0;
  bit     all_done = 1'b0;
  logic [TAGW-1:0] next_tag = '0;

  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [3*DW-1:0] vec3(input int x, input int y, input int z);
    return {DW'(z), DW'(y), DW'(x)};
  endfunction

  // Reference from R4..R7
  task automatic model(input logic [3*DW-1:0] a, b, o, r, input logic [DW-1:0] lim,
                       output bit hit, output longint ent);
    longint en, ex;
    en = -(longint'(1) <<< 60);
    ex =  (longint'(1) <<< 60);
    for (int i = 0; i < 3; i++) begin
      longint ca, cb, co, cr, ta, tb, tn, tf;
      ca = $signed(a[i*DW +: DW]);
      cb = $signed(b[i*DW +: DW]);
      co = $signed(o[i*DW +: DW]);
      cr = $signed(r[i*DW +: DW]);
      ta = ((ca - co) * cr) >>> FRAC;
      tb = ((cb - co) * cr) >>> FRAC;
      tn = (ta < tb) ? ta : tb;
      tf = (ta < tb) ? tb : ta;
      if (tn > en) en = tn;
      if (tf < ex) ex = tf;
    end
    hit = (en <= ex) && (ex >= 0) && (en < longint'($signed(lim)));
    ent = en;
  endtask

  task automatic issue(input logic [3*DW-1:0] a, b, o, r, input int lim,
                       input string req);
    exp_t e;
    bit h;
    longint en;
    @(negedge clk);
    in_valid = 1'b1;
    in_tag   = next_tag;
    corner_a = a; corner_b = b; ray_org = o; ray_rinv = r;
    t_limit  = DW'(lim);
    model(a, b, o, r, DW'(lim), h, en);
    e.tag = next_tag; e.hit = h; e.entry = en; e.req = req;
    e.due = edge_cnt + 1 + 7;
    sb_q.push_back(e);
    next_tag = next_tag + 1'b1;
  endtask

  // R8: idle cycles carry garbage data
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_tag   = TAGW'($urandom);
      corner_a = 3*DW'({$urandom, $urandom});
      corner_b = 3*DW'({$urandom, $urandom});
      ray_org  = 3*DW'({$urandom, $urandom});
      ray_rinv = 3*DW'({$urandom, $urandom});
      t_limit  = DW'($urandom);
    end
  endtask

  // Monitor
  always @(negedge clk) begin
    if (mon_on) begin
      bit due_now;
      due_now = (sb_q.size() > 0) && (sb_q[0].due == edge_cnt);
      check(out_valid === due_now, "R2/R8", "out_valid timing", out_valid, due_now);
      if (!due_now)
        check(out_hit === 1'b0, "R8", "out_hit while idle", out_hit, 0);
      if (due_now) begin
        exp_t e;
        e = sb_q.pop_front();
        check(out_tag === e.tag, "R3", "tag", out_tag, e.tag);
        check(out_hit === e.hit, e.req, "hit", out_hit, e.hit);
        check(longint'($signed(out_entry)) == e.entry, "R6", {"entry for ", e.req},
              longint'($signed(out_entry)), e.entry);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!all_done) begin
      n_errors++;
      n_checks++;
      $display("FAIL R2 watchdog expired: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0; in_tag = '0; t_limit = '0;
    corner_a = '0; corner_b = '0; ray_org = '0; ray_rinv = '0;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(out_valid === 1'b0, "R1", "out_valid in reset", out_valid, 0);
    check(out_hit === 1'b0, "R1", "out_hit in reset", out_hit, 0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    idle(3);

    // R4: straight hit, unit reciprocal
    issue(vec3(ONE, ONE, ONE), vec3(2*ONE, 2*ONE, 2*ONE), vec3(0, 0, 0),
          vec3(ONE, ONE, ONE), 2047, "R4");
    // R5: corners swapped
    issue(vec3(2*ONE, 2*ONE, 2*ONE), vec3(ONE, ONE, ONE), vec3(0, 0, 0),
          vec3(ONE, ONE, ONE), 2047, "R5");
    // R5: negative reciprocal, ray travelling toward -x/-y/-z
    issue(vec3(ONE, ONE, ONE), vec3(2*ONE, 2*ONE, 2*ONE), vec3(3*ONE, 3*ONE, 3*ONE),
          vec3(-ONE, -ONE, -ONE), 2047, "R5");
    // R7: box behind origin
    issue(vec3(ONE, ONE, ONE), vec3(2*ONE, 2*ONE, 2*ONE), vec3(4*ONE, 4*ONE, 4*ONE),
          vec3(ONE, ONE, ONE), 2047, "R7");
    // R7: origin inside
    issue(vec3(ONE, ONE, ONE), vec3(2*ONE, 2*ONE, 2*ONE), vec3(24, 24, 24),
          vec3(ONE, ONE, ONE), 2047, "R7");
    // R7: entry equal to limit misses, one below hits
    issue(vec3(ONE, ONE, ONE), vec3(2*ONE, 2*ONE, 2*ONE), vec3(0, 0, 0),
          vec3(ONE, ONE, ONE), ONE, "R7");
    issue(vec3(ONE, ONE, ONE), vec3(2*ONE, 2*ONE, 2*ONE), vec3(0, 0, 0),
          vec3(ONE, ONE, ONE), ONE + 1, "R7");
    // R6/R7: touching (entry == exit) hits; disjoint slabs miss
    issue(vec3(ONE, 2*ONE, ONE), vec3(2*ONE, 3*ONE, 2*ONE), vec3(0, 0, 0),
          vec3(ONE, ONE, ONE), 2047, "R7");
    issue(vec3(ONE, 3*ONE, ONE), vec3(2*ONE, 4*ONE, 2*ONE), vec3(0, 0, 0),
          vec3(ONE, ONE, ONE), 2047, "R6");
    // R6: different reciprocals per axis
    issue(vec3(ONE, -ONE, 0), vec3(3*ONE, 2*ONE, 4*ONE), vec3(0, 0, -ONE),
          vec3(2*ONE, ONE/2, -ONE), 2047, "R6");
    idle(2);
    // R4: extreme values
    issue(vec3(2047, -2048, 2047), vec3(-2048, 2047, -2048), vec3(-2048, 2047, -2048),
          vec3(-2048, 2047, -2048), 2047, "R4");
    issue(vec3(-2048, -2048, -2048), vec3(2047, 2047, 2047), vec3(2047, -2048, 0),
          vec3(2047, 2047, -2048), -2048, "R4");
    idle(4);

    // R2/R3/R8: streamed, mixed gaps, biased toward hits
    for (int n = 0; n < 600; n++) begin
      int ox, oy, oz, lo, hi;
      ox = $urandom_range(0, 64) - 32;
      oy = $urandom_range(0, 64) - 32;
      oz = $urandom_range(0, 64) - 32;
      lo = $urandom_range(0, 200) - 100;
      hi = lo + $urandom_range(0, 200);
      issue(vec3(lo, lo + 5, hi), vec3(hi, hi - 3, lo), vec3(ox, oy, oz),
            vec3($urandom_range(0, 128) - 64, $urandom_range(0, 128) - 64,
                 $urandom_range(0, 128) - 64),
            $urandom_range(0, 4095) - 2048, "R2");
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    for (int n = 0; n < 200; n++) begin
      issue(3*DW'({$urandom, $urandom}), 3*DW'({$urandom, $urandom}),
            3*DW'({$urandom, $urandom}), 3*DW'({$urandom, $urandom}),
            $urandom_range(0, 4095) - 2048, "R4");
    end
    idle(12);
    check(sb_q.size() == 0, "R2", "results outstanding", sb_q.size(), 0);
    all_done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule